// File: doc/BRIEF.md
# Dual-Convention Host Bus Lane Interface

This block is the slave end of a host processor bus. It gives the host access to a bank of 16-bit control registers and to two byte queues. A transmit queue is filled by host writes and drained by the internal side. A receive queue is filled by the internal side and drained by host reads. Two static configuration inputs set the bus. One picks which byte-enable convention is in force, where the enable marks either the high or the low half of the data bus. The other picks an 8-bit or a 16-bit data path. A third input selects a multiplexed bus. In that case the address is captured from the data pins while address-latch-enable is high.

Every access is classified as a word, an even byte, an odd byte or no transfer. The class comes from the active-low byte enable and address bit 0. The two conventions classify the same way and differ only in which data pins carry the even and odd bytes. A word access at the queue address moves two bytes in one access, and the host may mix byte and word accesses freely. A word access that cannot be completed in full is refused as a whole. Host access is strobe based: chip-select together with read or write, all active low. Each strobe acts once, on the first clock edge at which it is seen.

Address map with the default parameters: the queues sit at 0x00/0x01. Register n sits at 0x10+2n, with its even byte at the even address. Address bits [3:1] select among 8 registers.

Top module: `host_lane_if`

## Requirements
- R1: Access class from {byte enable bsel_ni, A0} in 16-bit mode: 00 word, 01 odd byte, 10 even byte, 11 no transfer. A no-transfer write changes nothing. A no-transfer read returns 0 with both lane enables off.
- R2: With lo_conv_i=0, the even byte uses D[7:0] (data_oe_o[0]) and the odd byte uses D[15:8] (data_oe_o[1]). A word therefore reads as {odd,even}.
- R3: With lo_conv_i=1, the even byte uses D[15:8] and the odd byte uses D[7:0]. A word therefore reads as {even,odd}.
- R4: With wide_bus_i=0, every access is a byte access on D[7:0], with A0 choosing the even or odd byte. bsel_ni is ignored, and data_oe_o[1] stays 0.
- R5: data_oe_o is nonzero only while cs_ni and rd_ni are both low, starting from the first clock edge of the read. Only the lanes of the decoded class are enabled, and undriven lanes read as 0 on data_o.
- R6: A register write takes effect at the first clock edge with cs_ni and wr_ni both low. It updates only the bytes of the decoded class, even byte into bits [7:0] and odd byte into bits [15:8], and it acts once per strobe.
- R7: A write at the queue address pushes onto the 64-byte transmit queue. A word push stores the even byte first, then the odd byte. A word push with fewer than 2 bytes free, or a byte push with the queue full, is dropped. The internal side sees the oldest byte on tx_byte_o while tx_valid_o is high and removes it with tx_pop_i.
- R8: A read at the queue address pops the 64-byte receive queue. A word pop returns the oldest byte as the even byte and the next as the odd byte. A word pop with fewer than 2 bytes stored, or a byte pop on an empty queue, returns 0 and removes nothing. rx_push_i stores rx_byte_i when rx_ready_o is high.
- R9: Byte and word queue accesses may follow one another in any order, and byte order in the queue is always preserved.
- R10: With mux_addr_i=1, the access address is data_i[7:0] as captured at the last clock edge with ale_i high, and addr_i is ignored. With mux_addr_i=0, addr_i is used.
- R11: Addresses outside the queue and register windows read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_conv_i | input | 1 | Byte-enable convention: 0 enable marks high half, 1 enable marks low half |
| wide_bus_i | input | 1 | 1 selects 16-bit data bus, 0 selects 8-bit |
| mux_addr_i | input | 1 | 1 takes the address from the latched data bus |
| ale_i | input | 1 | Address-latch-enable for multiplexed bus |
| addr_i | input | AW | Non-multiplexed address |
| cs_ni | input | 1 | Chip-select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| bsel_ni | input | 1 | Byte enable, active low |
| data_i | input | 16 | Data (and address in multiplexed mode) from host |
| data_o | output | 16 | Read data to host |
| data_oe_o | output | 2 | Lane output enables: bit 0 D[7:0], bit 1 D[15:8] |
| tx_pop_i | input | 1 | Internal side removes one transmit byte |
| tx_byte_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit queue not empty |
| rx_push_i | input | 1 | Internal side stores one receive byte |
| rx_byte_i | input | 8 | Receive byte to store |
| rx_ready_o | output | 1 | Receive queue not full |
| regs_o | output | NREG*16 | Register contents, register n at bits [16n+15:16n] |

## Verification
The assertions assume a host that keeps each strobe low for at least one full clock and returns to idle for at least one clock between accesses. They also assume that read and write are never active together, and that the two configuration inputs, the address and the byte enable stay still for the length of an access. The bench meets these assumptions in the same way for every access. Bus tasks change inputs only on the falling clock edge. Each access holds its strobe for exactly one clock and is followed by one idle clock. Configuration and address are set in the same step that lowers the strobe. In multiplexed mode, ale_i is pulsed only while no strobe is active.

// File: rtl/host_lane_pkg.sv
package host_lane_pkg;
  // bit 0: even byte involved, bit 1: odd byte involved
  typedef enum logic [1:0] {
    XF_NONE = 2'b00,
    XF_EVEN = 2'b01,
    XF_ODD  = 2'b10,
    XF_WORD = 2'b11
  } xfer_e;
endpackage

// File: rtl/host_lane_decode.sv
module host_lane_decode
  import host_lane_pkg::*;
(
  input  logic        lo_conv_i,
  input  logic        wide_bus_i,
  input  logic        bsel_ni,
  input  logic        a0_i,
  input  logic [15:0] data_i,
  output xfer_e       xfer_o,
  output logic        even_hi_o,
  output logic        odd_hi_o,
  output logic [7:0]  wr_even_o,
  output logic [7:0]  wr_odd_o
);
  always_comb begin
    if (!wide_bus_i) begin
      xfer_o = a0_i ? XF_ODD : XF_EVEN;
    end else begin
      unique case ({bsel_ni, a0_i})
        2'b00:   xfer_o = XF_WORD;
        2'b01:   xfer_o = XF_ODD;
        2'b10:   xfer_o = XF_EVEN;
        default: xfer_o = XF_NONE;
      endcase
    end
  end

  // lane placement is the only difference between the conventions
  assign even_hi_o = wide_bus_i & lo_conv_i;
  assign odd_hi_o  = wide_bus_i & ~lo_conv_i;
  assign wr_even_o = even_hi_o ? data_i[15:8] : data_i[7:0];
  assign wr_odd_o  = odd_hi_o  ? data_i[15:8] : data_i[7:0];

  always_comb begin
    assert (!(xfer_o == XF_WORD && even_hi_o == odd_hi_o))
      else $error("assert_word_split_lanes_R2");
  end
endmodule

// File: rtl/host_lane_fifo.sv
module host_lane_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_two_i,
  input  logic [W-1:0]  push_b0_i,
  input  logic [W-1:0]  push_b1_i,
  input  logic          pop_i,
  input  logic          pop_two_i,
  output logic [W-1:0]  head0_o,
  output logic [W-1:0]  head1_o,
  output logic [CW-1:0] count_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] count_q, free, n_in, n_out;

  assign free      = CW'(DEPTH) - count_q;
  assign push_ok_o = push_i & (push_two_i ? (free >= CW'(2)) : (free != '0));
  assign pop_ok_o  = pop_i & (pop_two_i ? (count_q >= CW'(2)) : (count_q != '0));
  assign n_in      = push_ok_o ? (push_two_i ? CW'(2) : CW'(1)) : '0;
  assign n_out     = pop_ok_o ? (pop_two_i ? CW'(2) : CW'(1)) : '0;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) begin
      mem_q[wp_q] <= push_b0_i;
      if (push_two_i) mem_q[wp_q + PW'(1)] <= push_b1_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
    end else begin
      wp_q    <= wp_q + PW'(n_in);
      rp_q    <= rp_q + PW'(n_out);
      count_q <= count_q + n_in - n_out;
    end
  end

  assign head0_o = mem_q[rp_q];
  assign head1_o = mem_q[rp_q + PW'(1)];
  assign count_o = count_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_refused_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !push_ok_o && !pop_ok_o) |=> count_q == $past(count_q));
  assert_refused_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !pop_ok_o && !push_ok_o) |=> count_q == $past(count_q));
endmodule

// File: rtl/host_lane_regs.sv
module host_lane_regs #(
  parameter int unsigned NREG = 8,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [1:0]        byte_en_i,
  input  logic [7:0]        wr_even_i,
  input  logic [7:0]        wr_odd_i,
  output logic [15:0]       rd_word_o,
  output logic [NREG*16-1:0] regs_o
);
  logic [15:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && idx_i == IDXW'(g)) begin
        if (byte_en_i[0]) regs_q[g][7:0]  <= wr_even_i;
        if (byte_en_i[1]) regs_q[g][15:8] <= wr_odd_i;
      end
    end
    assign regs_o[g*16 +: 16] = regs_q[g];
  end

  assign rd_word_o = regs_q[idx_i];

  assert_reg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/host_lane_if.sv
module host_lane_if
  import host_lane_pkg::*;
#(
  parameter int unsigned    AW         = 8,
  parameter int unsigned    FIFO_DEPTH = 64,
  parameter int unsigned    NREG       = 8,
  parameter logic [AW-1:0]  FIFO_ADDR  = AW'(0),
  parameter logic [AW-1:0]  REG_BASE   = AW'(16)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lo_conv_i,
  input  logic               wide_bus_i,
  input  logic               mux_addr_i,
  input  logic               ale_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               cs_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic               bsel_ni,
  input  logic [15:0]        data_i,
  output logic [15:0]        data_o,
  output logic [1:0]         data_oe_o,
  input  logic               tx_pop_i,
  output logic [7:0]         tx_byte_o,
  output logic               tx_valid_o,
  input  logic               rx_push_i,
  input  logic [7:0]         rx_byte_i,
  output logic               rx_ready_o,
  output logic [NREG*16-1:0] regs_o
);
  localparam int unsigned IDXW = $clog2(NREG);
  localparam int unsigned CW   = $clog2(FIFO_DEPTH) + 1;

  logic [AW-1:0] addr_lat_q, eff_addr;
  logic          rd_act, wr_act, rd_seen_q, wr_seen_q, rd_fire, wr_fire;
  logic          hit_fifo, hit_reg;
  xfer_e         xfer;
  logic          even_hi, odd_hi;
  logic [7:0]    wr_even, wr_odd, rd_even, rd_odd;
  logic [15:0]   rd_data, rdata_q, reg_rd;
  logic [1:0]    rd_lanes, lanes_q;
  logic          tx_push, rx_pop, tx_pop;
  logic [7:0]    tx_head0, tx_head1, rx_head0, rx_head1;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic          unused_fifo;

  // address capture for multiplexed bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_lat_q <= '0;
    else if (ale_i) addr_lat_q <= data_i[AW-1:0];
  end
  assign eff_addr = mux_addr_i ? addr_lat_q : addr_i;

  assign rd_act  = ~cs_ni & ~rd_ni;
  assign wr_act  = ~cs_ni & ~wr_ni;
  assign rd_fire = rd_act & ~rd_seen_q;
  assign wr_fire = wr_act & ~wr_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_seen_q <= 1'b0;
      wr_seen_q <= 1'b0;
    end else begin
      rd_seen_q <= rd_act;
      wr_seen_q <= wr_act;
    end
  end

  assign hit_fifo = eff_addr[AW-1:1] == FIFO_ADDR[AW-1:1];
  assign hit_reg  = eff_addr[AW-1:IDXW+1] == REG_BASE[AW-1:IDXW+1];

  host_lane_decode i_decode (
    .lo_conv_i  (lo_conv_i),
    .wide_bus_i (wide_bus_i),
    .bsel_ni    (bsel_ni),
    .a0_i       (eff_addr[0]),
    .data_i     (data_i),
    .xfer_o     (xfer),
    .even_hi_o  (even_hi),
    .odd_hi_o   (odd_hi),
    .wr_even_o  (wr_even),
    .wr_odd_o   (wr_odd)
  );

  host_lane_regs #(.NREG(NREG)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_fire & hit_reg & (xfer != XF_NONE)),
    .idx_i     (eff_addr[IDXW:1]),
    .byte_en_i (xfer),
    .wr_even_i (wr_even),
    .wr_odd_i  (wr_odd),
    .rd_word_o (reg_rd),
    .regs_o    (regs_o)
  );

  assign tx_push = wr_fire & hit_fifo & (xfer != XF_NONE);
  assign rx_pop  = rd_fire & hit_fifo & (xfer != XF_NONE);
  assign tx_pop  = tx_pop_i & tx_valid_o;

  host_lane_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_tx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (tx_push),
    .push_two_i (xfer == XF_WORD),
    .push_b0_i  ((xfer == XF_ODD) ? wr_odd : wr_even),
    .push_b1_i  (wr_odd),
    .pop_i      (tx_pop),
    .pop_two_i  (1'b0),
    .head0_o    (tx_head0),
    .head1_o    (tx_head1),
    .count_o    (tx_count),
    .push_ok_o  (tx_push_ok),
    .pop_ok_o   (tx_pop_ok)
  );

  host_lane_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_rx_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_push_i),
    .push_two_i (1'b0),
    .push_b0_i  (rx_byte_i),
    .push_b1_i  (8'h00),
    .pop_i      (rx_pop),
    .pop_two_i  (xfer == XF_WORD),
    .head0_o    (rx_head0),
    .head1_o    (rx_head1),
    .count_o    (rx_count),
    .push_ok_o  (rx_push_ok),
    .pop_ok_o   (rx_pop_ok)
  );

  assign unused_fifo = ^{tx_head1, tx_push_ok, tx_pop_ok, rx_push_ok};
  assign tx_byte_o   = tx_head0;
  assign tx_valid_o  = tx_count != '0;
  assign rx_ready_o  = rx_count != CW'(FIFO_DEPTH);

  // read byte selection
  always_comb begin
    rd_even = '0;
    rd_odd  = '0;
    if (hit_fifo) begin
      if (rx_pop_ok) begin
        rd_even = rx_head0;
        rd_odd  = (xfer == XF_WORD) ? rx_head1 : rx_head0;
      end
    end else if (hit_reg) begin
      rd_even = reg_rd[7:0];
      rd_odd  = reg_rd[15:8];
    end
  end

  // read lane steering
  always_comb begin
    rd_data  = '0;
    rd_lanes = '0;
    if (xfer[0]) begin
      rd_lanes[even_hi] = 1'b1;
      if (even_hi) rd_data[15:8] = rd_even;
      else         rd_data[7:0]  = rd_even;
    end
    if (xfer[1]) begin
      rd_lanes[odd_hi] = 1'b1;
      if (odd_hi) rd_data[15:8] = rd_odd;
      else        rd_data[7:0]  = rd_odd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      lanes_q <= '0;
    end else if (rd_fire) begin
      rdata_q <= rd_data;
      lanes_q <= rd_lanes;
    end
  end

  assign data_o    = rdata_q;
  assign data_oe_o = (rd_act & rd_seen_q) ? lanes_q : 2'b00;

  assert_oe_needs_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o != 2'b00) |-> (!cs_ni && !rd_ni));
  assert_narrow_low_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && !wide_bus_i) |=> lanes_q == 2'b01);
  assert_none_no_lanes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && xfer == XF_NONE) |=> (lanes_q == 2'b00 && rdata_q == 16'h0000));
  assert_refused_pop_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && !rx_pop_ok) |=> rdata_q == 16'h0000);
  assert_single_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !wr_fire);
endmodule

// File: tb/test_host_lane_if.sv
`timescale 1ns/1ps
module test_host_lane_if;
  typedef struct packed {
    logic        wr;
    logic        lo;
    logic        wide;
    logic        be_n;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [1:0]  oe;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b1,1'b0,8'h10,16'hA1B2,16'h0000,2'd0,4'd2},  // R2 word write
    '{1'b0,1'b0,1'b1,1'b0,8'h10,16'h0000,16'hA1B2,2'd3,4'd2},  // R2
    '{1'b0,1'b0,1'b1,1'b0,8'h11,16'h0000,16'hA100,2'd2,4'd2},  // R2 odd
    '{1'b0,1'b0,1'b1,1'b1,8'h10,16'h0000,16'h00B2,2'd1,4'd2},  // R2 even
    '{1'b0,1'b0,1'b1,1'b1,8'h11,16'h0000,16'h0000,2'd0,4'd1},  // R1 none
    '{1'b1,1'b0,1'b1,1'b1,8'h10,16'h77C3,16'h0000,2'd0,4'd6},  // R6 even byte only
    '{1'b1,1'b0,1'b1,1'b1,8'h11,16'h5555,16'h0000,2'd0,4'd1},  // R1 none write
    '{1'b0,1'b0,1'b1,1'b0,8'h10,16'h0000,16'hA1C3,2'd3,4'd6},  // R6
    '{1'b1,1'b1,1'b1,1'b0,8'h12,16'h1234,16'h0000,2'd0,4'd3},  // R3 word write
    '{1'b0,1'b1,1'b1,1'b0,8'h12,16'h0000,16'h1234,2'd3,4'd3},  // R3
    '{1'b0,1'b0,1'b1,1'b0,8'h12,16'h0000,16'h3412,2'd3,4'd3},  // R3 vs R2
    '{1'b0,1'b1,1'b1,1'b0,8'h13,16'h0000,16'h0034,2'd1,4'd3},  // R3 odd low
    '{1'b0,1'b1,1'b1,1'b1,8'h12,16'h0000,16'h1200,2'd2,4'd3},  // R3 even high
    '{1'b1,1'b1,1'b1,1'b1,8'h13,16'hFFFF,16'h0000,2'd0,4'd1},  // R1 none write
    '{1'b1,1'b1,1'b1,1'b0,8'h13,16'h00EE,16'h0000,2'd0,4'd3},  // R3 odd write
    '{1'b0,1'b0,1'b1,1'b0,8'h12,16'h0000,16'hEE12,2'd3,4'd6},  // R6
    '{1'b1,1'b1,1'b0,1'b1,8'h14,16'hFF5A,16'h0000,2'd0,4'd4},  // R4 even narrow
    '{1'b1,1'b0,1'b0,1'b0,8'h15,16'h0066,16'h0000,2'd0,4'd4},  // R4 odd narrow
    '{1'b0,1'b0,1'b0,1'b1,8'h15,16'h0000,16'h0066,2'd1,4'd4},  // R4 enable ignored
    '{1'b0,1'b0,1'b0,1'b0,8'h14,16'h0000,16'h005A,2'd1,4'd4},  // R4
    '{1'b0,1'b1,1'b0,1'b1,8'h15,16'h0000,16'h0066,2'd1,4'd4},  // R4 low conv
    '{1'b0,1'b0,1'b1,1'b0,8'h20,16'h0000,16'h0000,2'd3,4'd11}, // R11
    '{1'b1,1'b0,1'b1,1'b0,8'h20,16'hDEAD,16'h0000,2'd0,4'd11}, // R11
    '{1'b0,1'b0,1'b1,1'b0,8'h20,16'h0000,16'h0000,2'd3,4'd11}, // R11
    '{1'b0,1'b0,1'b1,1'b0,8'h10,16'h0000,16'hA1C3,2'd3,4'd11}  // R11 no alias
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lo_conv = 1'b0, wide_bus = 1'b1, mux_addr = 1'b0, ale = 1'b0;
  logic [7:0]   addr = '0;
  logic         cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, bsel_n = 1'b1;
  logic [15:0]  data_in = '0;
  logic [15:0]  data_out;
  logic [1:0]   data_oe;
  logic         tx_pop = 1'b0, tx_valid, rx_push = 1'b0, rx_ready;
  logic [7:0]   tx_byte, rx_byte = '0;
  logic [127:0] regs;
  int           n_checks = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  host_lane_if i_host_lane_if (
    .clk_i(clk), .rst_ni(rst_n), .lo_conv_i(lo_conv), .wide_bus_i(wide_bus),
    .mux_addr_i(mux_addr), .ale_i(ale), .addr_i(addr), .cs_ni(cs_n),
    .rd_ni(rd_n), .wr_ni(wr_n), .bsel_ni(bsel_n), .data_i(data_in),
    .data_o(data_out), .data_oe_o(data_oe), .tx_pop_i(tx_pop),
    .tx_byte_o(tx_byte), .tx_valid_o(tx_valid), .rx_push_i(rx_push),
    .rx_byte_i(rx_byte), .rx_ready_o(rx_ready), .regs_o(regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic lo, input logic wide, input logic be_n,
                        input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    lo_conv = lo; wide_bus = wide; bsel_n = be_n; addr = a; data_in = d;
    cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic lo, input logic wide, input logic be_n,
                        input logic [7:0] a, output logic [15:0] d, output logic [1:0] oe);
    @(negedge clk);
    lo_conv = lo; wide_bus = wide; bsel_n = be_n; addr = a; data_in = '0;
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    d = data_out; oe = data_oe;
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {24'h0, tx_byte}, {24'h0, exp});
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic [1:0]  oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R5, R7, R8, R6)
    chk("R5 reset oe", {30'h0, data_oe}, 32'h0);
    chk("R7 reset tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R8 reset rx_ready", {31'h0, rx_ready}, 32'h1);
    chk("R6 reset regs", {31'h0, regs != '0}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        bus_wr(VEC[i].lo, VEC[i].wide, VEC[i].be_n, VEC[i].addr, VEC[i].wd);
      end else begin
        bus_rd(VEC[i].lo, VEC[i].wide, VEC[i].be_n, VEC[i].addr, d, oe);
        chk($sformatf("R%0d vec %0d data", VEC[i].req, i), {16'h0, d}, {16'h0, VEC[i].exp});
        chk($sformatf("R%0d vec %0d oe", VEC[i].req, i), {30'h0, oe}, {30'h0, VEC[i].oe});
      end
    end

    // R6: write side visible on the register port
    chk("R6 regs_o reg1", {16'h0, regs[31:16]}, 32'h0000EE12);

    // R5: no enables without chip-select, none before the first edge
    @(negedge clk);
    addr = 8'h10; wide_bus = 1'b1; lo_conv = 1'b0; bsel_n = 1'b0;
    rd_n = 1'b0;
    @(negedge clk);
    chk("R5 no cs", {30'h0, data_oe}, 32'h0);
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    #1;
    chk("R5 before edge", {30'h0, data_oe}, 32'h0);
    @(negedge clk);
    chk("R5 after edge", {30'h0, data_oe}, 32'h3);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);

    // R10: multiplexed address
    @(negedge clk);
    mux_addr = 1'b1; data_in = 16'h0012; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    bus_rd(1'b0, 1'b1, 1'b0, 8'h40, d, oe);
    chk("R10 mux read", {16'h0, d}, 32'h0000EE12);
    @(negedge clk);
    data_in = 16'h0014; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
    bus_wr(1'b0, 1'b1, 1'b0, 8'h00, 16'hCAFE);
    mux_addr = 1'b0;
    bus_rd(1'b0, 1'b1, 1'b0, 8'h14, d, oe);
    chk("R10 mux write", {16'h0, d}, 32'h0000CAFE);
    chk("R10 addr_i ignored", {31'h0, tx_valid}, 32'h0);

    // R8 / R9: receive queue
    rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
    bus_rd(1'b0, 1'b1, 1'b0, 8'h00, d, oe);
    chk("R8 word pop", {16'h0, d}, 32'h00002211);
    bus_rd(1'b0, 1'b1, 1'b0, 8'h00, d, oe);
    chk("R8 word pop refused", {16'h0, d}, 32'h0);
    bus_rd(1'b0, 1'b1, 1'b1, 8'h00, d, oe);
    chk("R9 byte after word", {16'h0, d}, 32'h00000033);
    bus_rd(1'b0, 1'b1, 1'b0, 8'h01, d, oe);
    chk("R8 empty byte pop", {16'h0, d}, 32'h0);
    chk("R8 empty byte oe", {30'h0, oe}, 32'h2);
    rx_put(8'h44); rx_put(8'h55);
    bus_rd(1'b1, 1'b1, 1'b0, 8'h00, d, oe);
    chk("R8 R3 word pop low conv", {16'h0, d}, 32'h00004455);
    for (int i = 0; i < 64; i++) rx_put(8'(i));
    chk("R8 rx full", {31'h0, rx_ready}, 32'h0);
    rx_put(8'hEE);
    for (int i = 0; i < 32; i++) begin
      bus_rd(1'b0, 1'b1, 1'b0, 8'h00, d, oe);
      chk($sformatf("R8 drain %0d", i), {16'h0, d}, {16'h0, 8'(2*i+1), 8'(2*i)});
    end
    bus_rd(1'b0, 1'b1, 1'b1, 8'h00, d, oe);
    chk("R8 dropped when full", {16'h0, d}, 32'h0);

    // R7 / R9: transmit queue
    bus_wr(1'b0, 1'b1, 1'b0, 8'h00, 16'hBBAA);
    bus_wr(1'b0, 1'b1, 1'b1, 8'h00, 16'h00CC);
    bus_wr(1'b0, 1'b1, 1'b0, 8'h01, 16'hDD00);
    bus_wr(1'b1, 1'b1, 1'b0, 8'h00, 16'h1122);
    tx_take("R7 word even first", 8'hAA);
    tx_take("R7 word odd second", 8'hBB);
    tx_take("R9 even byte", 8'hCC);
    tx_take("R9 odd byte", 8'hDD);
    tx_take("R7 R3 low conv even", 8'h11);
    tx_take("R7 R3 low conv odd", 8'h22);
    @(negedge clk);
    chk("R7 tx empty", {31'h0, tx_valid}, 32'h0);
    for (int i = 0; i < 31; i++)
      bus_wr(1'b0, 1'b1, 1'b0, 8'h00, {8'(2*i+1), 8'(2*i)});
    bus_wr(1'b0, 1'b1, 1'b1, 8'h00, 16'h003E);
    bus_wr(1'b0, 1'b1, 1'b0, 8'h00, 16'h9988); // refused, 1 free
    bus_wr(1'b0, 1'b1, 1'b1, 8'h00, 16'h0077);
    bus_wr(1'b0, 1'b1, 1'b1, 8'h00, 16'h0066); // refused, full
    for (int i = 0; i < 63; i++) tx_take($sformatf("R7 fill %0d", i), 8'(i));
    tx_take("R7 word refused", 8'h77);
    @(negedge clk);
    chk("R7 full push dropped", {31'h0, tx_valid}, 32'h0);

    finish_run();
  end
endmodule